// File: doc/BRIEF.md
# DMA Address Remapping Page Walker

This block turns the address carried by a device's DMA request into a system physical address. A request brings a 16-bit requester identifier and a 48-bit device-virtual address. The walker first reads two device assignment levels. The first level is indexed by the bus number. The second level is indexed by the combined device and function number, and its entry names the root of that device's private page table. The walker then descends four page-table levels and returns either the physical address of the 4 KB page, with the page offset appended, or a fault. The fault carries a code that names the level at which the walk stopped.

All table reads go out through a simple read port. The walker raises a one-cycle request with an 8-byte-aligned address and then waits, for as many cycles as needed, for a one-cycle response that carries the 64-bit entry. Only one walk runs at a time. The base of the bus-indexed table sits in a register that can be loaded only while the walker is idle.

Top module: `dma_page_walker`

## Requirements
- R1: After reset `reqReady` is 1, `rspValid` is 0, `memReqValid` is 0 and the table base register holds 0.
- R2: The requester identifier is split into bus = bits 15:8 and devfn = bits 7:3 (device) with bits 2:0 (function). The first read is at table base + bus*8. The second read is at (bits 47:12 of the first entry)*4096 + devfn*8. Every read address has its low three bits at 000b.
- R3: The four page-table reads use these virtual-address slices as 9-bit indexes, in order: 47:39, 38:30, 29:21 and 20:12. Each read is at (bits 47:12 of the previous entry)*4096 + index*8.
- R4: On success `rspFault` is 0, `rspFaultCode` is 0 and `rspPaddr` = {bits 47:12 of the last entry, virtual address bits 11:0}.
- R5: Bit 0 of every entry is a present flag. A clear flag ends the walk at once, with no further read, and gives `rspFault`=1 and `rspPaddr`=0. The code is 1 for the bus level, 2 for the devfn level, and 3, 4, 5 or 6 for page levels 4, 3, 2 and 1.
- R6: `reqReady` is high only when idle. It falls in the cycle after a request is accepted and stays low until the response has been delivered. A `reqValid` raised while busy is ignored.
- R7: A write to the table base register (address bits 47:12 are kept) takes effect only while idle. A write during a walk is dropped.
- R8: At most one table read is outstanding. No read is issued while a response is being presented.
- R9: `rspValid` is a single-cycle pulse, and `reqReady` is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rootBaseWe | input | 1 | Load strobe for the bus-table base register |
| rootBaseWdata | input | 48 | New bus-table base (bits 47:12 used) |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to accept a request |
| reqRid | input | 16 | Requester identifier |
| reqVaddr | input | 48 | Device-virtual address |
| rspValid | output | 1 | Result pulse |
| rspFault | output | 1 | Walk failed |
| rspFaultCode | output | 3 | Failing level, 0 on success |
| rspPaddr | output | 48 | Translated physical address |
| memReqValid | output | 1 | Table read request pulse |
| memReqAddr | output | 48 | Entry address of the read |
| memRspValid | input | 1 | Read data pulse |
| memRspData | input | 64 | Entry read from memory |

## Verification
A corrupted level counter or index selection sends a read to an address where the bench memory holds nothing. The walk then ends in a fault whose code does not match, or it returns a page from some other mapping, and this is visible at the end of the same walk, within six reads. A walk that continues past a clear present flag shows up as an extra read before the response, and the bench counts the reads in every walk. A state machine that loses its way either never raises `reqReady` again, which the watchdog catches, or raises `rspValid` for a request that was never accepted.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int IDX_W      = 9;
  localparam int PT_LEVELS  = 4;
  localparam int CTX_LEVELS = 2;
  localparam int WALK_STEPS = PT_LEVELS + CTX_LEVELS;
  localparam int CODE_W     = $clog2(WALK_STEPS + 1);
  localparam int VA_W       = PAGE_SHIFT + PT_LEVELS * IDX_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } walkState_e;

  typedef struct packed {
    logic acceptReq;
    logic advance;
    logic finishOk;
    logic finishFault;
    logic cfgOpen;
  } ctrlStrobes_t;
endpackage

// File: rtl/dmaw_ctrl.sv
module dmaw_ctrl
  import dmaw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memRspValid,
  input  logic         entryPresent,
  input  logic         lastLevel,
  output logic         reqReady,
  output logic         rspValid,
  output logic         memReqValid,
  output ctrlStrobes_t strobes
);
  walkState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    case (stateQ)
      ST_IDLE: begin
        strobes.cfgOpen = 1'b1;
        if (reqValid) begin
          strobes.acceptReq = 1'b1;
          stateD = ST_ISSUE;
        end
      end
      ST_ISSUE: stateD = ST_WAIT;
      ST_WAIT: begin
        if (memRspValid) begin
          if (!entryPresent) begin
            strobes.finishFault = 1'b1;
            stateD = ST_RESP;
          end else if (lastLevel) begin
            strobes.finishOk = 1'b1;
            stateD = ST_RESP;
          end else begin
            strobes.advance = 1'b1;
            stateD = ST_ISSUE;
          end
        end
      end
      ST_RESP: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign reqReady    = (stateQ == ST_IDLE);
  assign memReqValid = (stateQ == ST_ISSUE);
  assign rspValid    = (stateQ == ST_RESP);
endmodule

// File: rtl/dmaw_datapath.sv
module dmaw_datapath
  import dmaw_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int RID_W  = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [RID_W-1:0]  reqRid,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              rootBaseWe,
  input  logic [ADDR_W-1:0] rootBaseWdata,
  input  logic [DATA_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              entryPresent,
  output logic              lastLevel,
  output logic              rspFault,
  output logic [CODE_W-1:0] rspFaultCode,
  output logic [ADDR_W-1:0] rspPaddr
);
  localparam int BASE_W  = ADDR_W - PAGE_SHIFT;
  localparam int SEL_W   = $clog2(PT_LEVELS);
  localparam int DEVFN_W = 8;

  logic [RID_W-1:0]  ridQ;
  logic [VA_W-1:0]   vaQ;
  logic [BASE_W-1:0] baseQ, rootBaseQ, curBase, entryBase;
  logic [CODE_W-1:0] lvlQ;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  ptIdx [PT_LEVELS];
  logic [SEL_W-1:0]  pgSel;
  logic              unusedBits;

  // page-table index for each level, level 1 at slot 0
  for (genvar g = 0; g < PT_LEVELS; g++) begin : g_ptIdx
    assign ptIdx[g] = vaQ[PAGE_SHIFT + g*IDX_W +: IDX_W];
  end

  assign pgSel     = SEL_W'(CODE_W'(WALK_STEPS - 1) - lvlQ);
  assign entryBase = memRspData[ADDR_W-1:PAGE_SHIFT];
  assign entryPresent = memRspData[0];
  assign lastLevel = (lvlQ == CODE_W'(WALK_STEPS - 1));
  assign curBase   = (lvlQ == '0) ? rootBaseQ : baseQ;
  assign unusedBits = ^{memRspData[DATA_W-1:ADDR_W], memRspData[PAGE_SHIFT-1:1],
                        rootBaseWdata[PAGE_SHIFT-1:0]};

  always_comb begin
    if (lvlQ == CODE_W'(0))      idx = IDX_W'(ridQ[RID_W-1:DEVFN_W]);
    else if (lvlQ == CODE_W'(1)) idx = IDX_W'(ridQ[DEVFN_W-1:0]);
    else                         idx = ptIdx[pgSel];
  end

  assign memReqAddr = {curBase, idx, 3'b000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rootBaseQ <= '0;
    end else if (rootBaseWe && strobes.cfgOpen) begin
      rootBaseQ <= rootBaseWdata[ADDR_W-1:PAGE_SHIFT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ridQ  <= '0;
      vaQ   <= '0;
      baseQ <= '0;
      lvlQ  <= '0;
    end else if (strobes.acceptReq) begin
      ridQ <= reqRid;
      vaQ  <= reqVaddr;
      lvlQ <= '0;
    end else if (strobes.advance) begin
      baseQ <= entryBase;
      lvlQ  <= lvlQ + CODE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspFault     <= 1'b0;
      rspFaultCode <= '0;
      rspPaddr     <= '0;
    end else if (strobes.finishOk) begin
      rspFault     <= 1'b0;
      rspFaultCode <= '0;
      rspPaddr     <= {entryBase, vaQ[PAGE_SHIFT-1:0]};
    end else if (strobes.finishFault) begin
      rspFault     <= 1'b1;
      rspFaultCode <= lvlQ + CODE_W'(1);
      rspPaddr     <= '0;
    end
  end
endmodule

// File: rtl/dma_page_walker.sv
module dma_page_walker
  import dmaw_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int RID_W  = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rootBaseWe,
  input  logic [ADDR_W-1:0] rootBaseWdata,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [RID_W-1:0]  reqRid,
  input  logic [VA_W-1:0]   reqVaddr,
  output logic              rspValid,
  output logic              rspFault,
  output logic [CODE_W-1:0] rspFaultCode,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData
);
  ctrlStrobes_t strobes;
  logic         entryPresent;
  logic         lastLevel;

  dmaw_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .entryPresent(entryPresent),
    .lastLevel   (lastLevel),
    .reqReady    (reqReady),
    .rspValid    (rspValid),
    .memReqValid (memReqValid),
    .strobes     (strobes)
  );

  dmaw_datapath #(
    .ADDR_W(ADDR_W),
    .RID_W (RID_W),
    .DATA_W(DATA_W)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .reqRid       (reqRid),
    .reqVaddr     (reqVaddr),
    .rootBaseWe   (rootBaseWe),
    .rootBaseWdata(rootBaseWdata),
    .memRspData   (memRspData),
    .memReqAddr   (memReqAddr),
    .entryPresent (entryPresent),
    .lastLevel    (lastLevel),
    .rspFault     (rspFault),
    .rspFaultCode (rspFaultCode),
    .rspPaddr     (rspPaddr)
  );
endmodule

// File: rtl/dmaw_checker.sv
module dmaw_checker
  import dmaw_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspFault,
  input logic [CODE_W-1:0] rspFaultCode,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid
);
  logic [1:0] outstanding;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outstanding <= '0;
    else if (memReqValid && !memRspValid) outstanding <= outstanding + 2'd1;
    else if (memRspValid && !memReqValid && outstanding != 2'd0) outstanding <= outstanding - 2'd1;
  end

  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);                                    // R6
  AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);                                             // R6
  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[2:0] == 3'b000);                             // R2
  AST_FAULT_CODE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> rspFaultCode != '0 && rspFaultCode <= CODE_W'(WALK_STEPS)); // R5
  AST_OK_CODE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault |-> rspFaultCode == '0);                          // R4
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);                                                // R9
  AST_READY_AFTER_RSP: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady);                                                 // R9
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> outstanding == 2'd0);                                   // R8
  AST_NO_READ_AT_RSP: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !memReqValid && outstanding == 2'd0);                      // R8
endmodule

bind dma_page_walker dmaw_checker #(.ADDR_W(ADDR_W)) i_dmaw_checker (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .rspValid    (rspValid),
  .rspFault    (rspFault),
  .rspFaultCode(rspFaultCode),
  .memReqValid (memReqValid),
  .memReqAddr  (memReqAddr),
  .memRspValid (memRspValid)
);

// File: tb/test_dma_page_walker.sv
`timescale 1ns/1ps
module test_dma_page_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rootBaseWe = 1'b0;
  logic [47:0] rootBaseWdata = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqRid = '0;
  logic [47:0] reqVaddr = '0;
  logic        rspValid, rspFault;
  logic [2:0]  rspFaultCode;
  logic [47:0] rspPaddr;
  logic        memReqValid;
  logic [47:0] memReqAddr;
  logic        memRspValid;
  logic [63:0] memRspData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_page_walker i_dma_page_walker (
    .clk(clk), .rstN(rstN), .rootBaseWe(rootBaseWe), .rootBaseWdata(rootBaseWdata),
    .reqValid(reqValid), .reqReady(reqReady), .reqRid(reqRid), .reqVaddr(reqVaddr),
    .rspValid(rspValid), .rspFault(rspFault), .rspFaultCode(rspFaultCode),
    .rspPaddr(rspPaddr), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  // ---------------- behavioural table memory ----------------
  logic [63:0] memArr [logic [47:0]];
  int          memLat = 0;
  int          readsTotal = 0;
  logic [47:0] pendAddr;
  int          pendCnt;
  logic        pend;

  function automatic logic [63:0] memRd(input logic [47:0] a);
    return memArr.exists(a) ? memArr[a] : 64'h0;
  endfunction

  initial begin
    memRspValid = 1'b0;
    memRspData  = '0;
    pend = 1'b0;
    pendCnt = 0;
    pendAddr = '0;
    forever begin
      @(posedge clk);
      memRspValid <= 1'b0;
      if (memReqValid) begin
        pendAddr <= memReqAddr;
        pendCnt  <= memLat;
        pend     <= 1'b1;
        readsTotal++;
      end else if (pend) begin
        if (pendCnt == 0) begin
          memRspValid <= 1'b1;
          memRspData  <= memRd(pendAddr);
          pend        <= 1'b0;
        end else begin
          pendCnt <= pendCnt - 1;
        end
      end
    end
  end

  // ---------------- reference model from the requirements ----------------
  logic [47:0] refRoot = 48'h0;
  logic [35:0] nextPg = 36'h100;

  function automatic logic [8:0] stepIdx(input int lv, input logic [15:0] rid, input logic [47:0] va);
    case (lv)
      0: return {1'b0, rid[15:8]};
      1: return {1'b0, rid[7:0]};
      2: return va[47:39];
      3: return va[38:30];
      4: return va[29:21];
      default: return va[20:12];
    endcase
  endfunction

  task automatic refWalk(input logic [15:0] rid, input logic [47:0] va,
                         output logic f, output logic [2:0] code,
                         output logic [47:0] pa, output int reads);
    logic [35:0] b = refRoot[47:12];
    logic [63:0] e;
    reads = 0; f = 0; code = 0; pa = 0;
    for (int lv = 0; lv < 6; lv++) begin
      e = memRd({b, stepIdx(lv, rid, va), 3'b000});
      reads++;
      if (!e[0]) begin
        f = 1; code = 3'(lv + 1); pa = 0;
        return;
      end
      b = e[47:12];
    end
    pa = {b, va[11:0]};
  endtask

  task automatic mapPage(input logic [15:0] rid, input logic [47:0] va, input logic [35:0] leafPg);
    logic [35:0] b = refRoot[47:12];
    logic [47:0] a;
    logic [63:0] e;
    for (int lv = 0; lv < 6; lv++) begin
      a = {b, stepIdx(lv, rid, va), 3'b000};
      if (lv == 5) begin
        memArr[a] = {16'h0, leafPg, 12'h001};
      end else begin
        e = memRd(a);
        if (!e[0]) begin
          memArr[a] = {16'h0, nextPg, 12'h001};
          nextPg = nextPg + 36'h1;
        end
        e = memArr[a];
        b = e[47:12];
      end
    end
  endtask

  task automatic setPresentAt(input logic [15:0] rid, input logic [47:0] va, input int lvStop, input logic v);
    logic [35:0] b = refRoot[47:12];
    logic [47:0] a;
    logic [63:0] e;
    for (int lv = 0; lv <= lvStop; lv++) begin
      a = {b, stepIdx(lv, rid, va), 3'b000};
      e = memRd(a);
      if (lv == lvStop) begin
        e[0] = v;
        memArr[a] = e;
      end
      b = e[47:12];
    end
  endtask

  // ---------------- scoreboard ----------------
  typedef struct {
    logic        f;
    logic [2:0]  code;
    logic [47:0] pa;
    int          reads;
    string       tag;
  } exp_t;
  exp_t expQ[$];
  int   lastReads = 0;

  initial begin
    exp_t e;
    int   nReads;
    forever begin
      @(negedge clk);
      if (rspValid) begin
        nReads = readsTotal - lastReads;
        lastReads = readsTotal;
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R6 unexpected response: fault=%0b code=%0d pa=%h expected none",
                   rspFault, rspFaultCode, rspPaddr);
        end else begin
          e = expQ.pop_front();
          if (rspFault !== e.f || rspFaultCode !== e.code || rspPaddr !== e.pa || nReads != e.reads) begin
            errors++;
            $display("FAIL %s: fault=%0b code=%0d pa=%h reads=%0d expected fault=%0b code=%0d pa=%h reads=%0d",
                     e.tag, rspFault, rspFaultCode, rspPaddr, nReads, e.f, e.code, e.pa, e.reads);
          end
        end
        @(negedge clk);
        checks++;
        if (rspValid !== 1'b0 || reqReady !== 1'b1) begin
          errors++;
          $display("FAIL R9 after response: rspValid=%0b reqReady=%0b expected 0 1", rspValid, reqReady);
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic startWalk(input logic [15:0] rid, input logic [47:0] va, input string tag);
    exp_t e;
    refWalk(rid, va, e.f, e.code, e.pa, e.reads);
    e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqRid   = rid;
    reqVaddr = va;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doWalk(input logic [15:0] rid, input logic [47:0] va, input string tag);
    startWalk(rid, va, tag);
    waitDone();
  endtask

  task automatic writeBase(input logic [47:0] v);
    @(negedge clk);
    rootBaseWe = 1'b1;
    rootBaseWdata = v;
    @(negedge clk);
    rootBaseWe = 1'b0;
  endtask

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  localparam logic [47:0] VA_A = 48'h1234_5678_9ABC;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady === 1'b1 && rspValid === 1'b0 && memReqValid === 1'b0,
        $sformatf("R1 reset outputs ready=%0b rsp=%0b mreq=%0b expected 1 0 0", reqReady, rspValid, memReqValid));

    // R1: base register resets to 0; an empty table at page 0 gives a bus-level fault
    doWalk(16'h0308, VA_A, "R1 base zero after reset");

    writeBase(48'h0000_0000_1FFF);   // low 12 bits dropped -> page 1
    refRoot = 48'h0000_0000_1000;

    mapPage(16'h0308, VA_A, 36'hA_BCDE_F012);
    doWalk(16'h0308, VA_A, "R2 R3 R4 basic walk");
    mapPage(16'h0308, VA_A ^ 48'h0000_0000_1000, 36'h0_0000_0777);
    doWalk(16'h0308, VA_A ^ 48'h0000_0000_1000, "R3 level-1 index differs");
    mapPage(16'h0308, VA_A ^ 48'h8000_0000_0000, 36'h0_0000_0888);
    doWalk(16'h0308, VA_A ^ 48'h8000_0000_0000, "R3 level-4 index differs");
    mapPage(16'h0309, VA_A, 36'h0_0000_0999);
    doWalk(16'h0309, VA_A, "R2 other function same bus");
    mapPage(16'hFFFF, 48'hFFFF_FFFF_FFFF, 36'hF_FFFF_FFFF);
    doWalk(16'hFFFF, 48'hFFFF_FFFF_FFFF, "R2 R4 bus 255 devfn 255 top address");
    mapPage(16'h0000, 48'h0, 36'h0_0000_0042);
    doWalk(16'h0000, 48'h0, "R2 R4 bus 0 devfn 0 zero address");
    doWalk(16'h0308, VA_A, "R4 repeat walk");

    // R5: a fault at each level
    doWalk(16'h7700, VA_A, "R5 code 1 bus entry absent");
    doWalk(16'h0310, VA_A, "R5 code 2 devfn entry absent");
    for (int lv = 2; lv < 6; lv++) begin
      setPresentAt(16'h0308, VA_A, lv, 1'b0);
      doWalk(16'h0308, VA_A, $sformatf("R5 code %0d page level absent", lv + 1));
      setPresentAt(16'h0308, VA_A, lv, 1'b1);
    end
    doWalk(16'h0308, VA_A, "R5 walk after restore");

    // R8: slower memory
    memLat = 3;
    doWalk(16'h0309, VA_A, "R8 slow memory success");
    doWalk(16'h0310, VA_A, "R8 slow memory fault");
    memLat = 1;

    // R6: request raised while busy is ignored
    startWalk(16'h0308, VA_A, "R6 walk with busy request");
    reqValid = 1'b1;
    reqRid   = 16'hFFFF;
    reqVaddr = 48'hFFFF_FFFF_FFFF;
    for (int i = 0; i < 2; i++) begin
      chk(reqReady === 1'b0, $sformatf("R6 ready while busy=%0b expected 0", reqReady));
      @(negedge clk);
    end
    reqValid = 1'b0;
    waitDone();
    repeat (4) @(negedge clk);
    chk(rspValid === 1'b0 && expQ.size() == 0, "R6 no second response");

    // R7: base write during a walk is dropped
    startWalk(16'h0308, VA_A, "R7 walk during base write");
    rootBaseWe = 1'b1;
    rootBaseWdata = 48'h0000_0000_5000;
    @(negedge clk);
    rootBaseWe = 1'b0;
    waitDone();
    doWalk(16'h0309, VA_A, "R7 busy write dropped, old base used");
    writeBase(48'h0000_0000_5000);
    refRoot = 48'h0000_0000_5000;
    doWalk(16'h0309, VA_A, "R7 idle write taken, new base empty");
    writeBase(48'h0000_0000_1000);
    refRoot = 48'h0000_0000_1000;
    doWalk(16'h0309, VA_A, "R7 base restored");

    memLat = 0;
    doWalk(16'hFFFF, 48'hFFFF_FFFF_FFFF, "R9 fastest memory");

    repeat (5) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule